// File: doc/BRIEF.md
# PHY Delay Register Access Bridge

This block gives software access to a small bank of 8-bit PHY delay settings through one 32-bit host register. Software places a PHY address and write data in the host register, then sets a write request or a read request in a second host write. The bridge carries out the access on the PHY register file after a fixed, parameterised latency. It then raises an acknowledge bit in the same host register. A read returns its byte in a dedicated read-data field.

The exchange is a four-phase handshake. The acknowledge stays high as long as a request bit is set. It drops once software clears both request bits. Requests are ignored until the acknowledge has fallen. The PHY side holds twelve delay bytes: the input-delay settings for the various bus timings sit at PHY addresses 0x00 through 0x08, and the clock, high-speed clock and strobe delay-line settings sit at 0x0B, 0x0C and 0x0D. All twelve bytes are presented on a flat output bus that feeds the delay lines.

Top module: `phy_regport`

## Requirements
- R1: After reset, host_rdata reads 0 and every delay byte on dly_flat is 0.
- R2: A host write stores PHY address from bits 5:0, write data from bits 15:8, write request from bit 24 and read request from bit 25. Bits 23:16 (read data) and bit 26 (acknowledge) are read-only. Bits 7:6, 22:16 excepted as read data, and 31:27 read as zero. A host write with bits 24 and 25 clear starts no access.
- R3: When a host write sets a request bit while the bridge is idle, the acknowledge (bit 26) rises exactly ACK_LAT+1 clock edges after that write's edge. It is low at ACK_LAT edges. A write request has updated the addressed delay byte by the time the acknowledge is high.
- R4: The acknowledge stays high while either request bit is set. It falls at the first clock edge after the edge of the host write that clears both request bits.
- R5: A read request loads the addressed byte into bits 23:16 no later than the edge where the acknowledge rises. That field keeps its value through later writes and host writes until the next read completes.
- R6: A request with bits 24 and 25 both set performs a write only, and the read-data field is left unchanged.
- R7: Only addresses 0x00–0x08 and 0x0B–0x0D hold a delay byte. A write to any other address changes no delay byte, a read of one returns 0, and both are acknowledged on the normal schedule.
- R8: Address, data or request changes made while an access is in flight do not alter that access. A request made while the acknowledge is high starts nothing.
- R9: Delay byte k occupies dly_flat[8k+7:8k], where k equals the PHY address for 0x00–0x08 and the address minus 2 for 0x0B–0x0D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the access register |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Current view of the access register |
| dly_flat | output | 96 | All delay bytes, slot k at bits 8k+7:8k |

## Verification
The bench targets the gap addresses 0x09 and 0x3F. A bridge that decoded them loosely would corrupt a neighbouring delay byte, or return stale data instead of zero. It counts edges to the acknowledge rise and fall, so a latency counter that is off by one, or an acknowledge released while a request is still set, shows at once. It also sets both request bits, and changes the address and data while an access is busy. A design that read as well as wrote, or that re-sampled the host fields mid-access, would leave the wrong byte in the wrong slot. It checks that the read-data field survives later writes. It checks that a request made while the acknowledge is high does nothing.

// File: rtl/phy_regport_pkg.sv
package phy_regport_pkg;

  localparam int PA_W   = 6;
  localparam int PD_W   = 8;
  localparam int HREG_W = 32;

  // host register field positions
  localparam int ADDR_LSB  = 0;
  localparam int WDATA_LSB = 8;
  localparam int RDATA_LSB = 16;
  localparam int WREQ_BIT  = 24;
  localparam int RREQ_BIT  = 25;
  localparam int ACK_BIT   = 26;

  // implemented PHY address map: one low run and one high run
  localparam int LOW_RUN   = 9;
  localparam int HIGH_BASE = 11;
  localparam int HIGH_RUN  = 3;
  localparam int NUM_SLOTS = LOW_RUN + HIGH_RUN;

  localparam logic [PA_W-1:0] LOW_END  = PA_W'(LOW_RUN);
  localparam logic [PA_W-1:0] HIGH_LO  = PA_W'(HIGH_BASE);
  localparam logic [PA_W-1:0] HIGH_END = PA_W'(HIGH_BASE + HIGH_RUN);

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_WAIT = 2'd1,
    PS_DONE = 2'd2
  } port_state_e;

  function automatic logic [PA_W-1:0] slot_to_addr(input int s);
    if (s < LOW_RUN) return PA_W'(s);
    return PA_W'(HIGH_BASE + s - LOW_RUN);
  endfunction

  function automatic logic addr_hit(input logic [PA_W-1:0] a);
    return (a < LOW_END) || ((a >= HIGH_LO) && (a < HIGH_END));
  endfunction

  function automatic logic [HREG_W-1:0] pack_view(
    input logic [PA_W-1:0] addr,
    input logic [PD_W-1:0] wdata,
    input logic [PD_W-1:0] rdata,
    input logic            wreq,
    input logic            rreq,
    input logic            ack
  );
    logic [HREG_W-1:0] v;
    v = '0;
    v[ADDR_LSB  +: PA_W] = addr;
    v[WDATA_LSB +: PD_W] = wdata;
    v[RDATA_LSB +: PD_W] = rdata;
    v[WREQ_BIT]          = wreq;
    v[RREQ_BIT]          = rreq;
    v[ACK_BIT]           = ack;
    return v;
  endfunction

endpackage

// File: rtl/regport_hostreg.sv
module regport_hostreg
  import phy_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [HREG_W-1:0] host_wdata,
  input  logic              rd_load,
  input  logic [PD_W-1:0]   rd_value,
  input  logic              ack,
  output logic [HREG_W-1:0] host_rdata,
  output logic [PA_W-1:0]   req_addr,
  output logic [PD_W-1:0]   req_wdata,
  output logic              req_wr,
  output logic              req_rd
);

  logic [PD_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_addr  <= '0;
      req_wdata <= '0;
      req_wr    <= 1'b0;
      req_rd    <= 1'b0;
    end else if (host_we) begin
      req_addr  <= host_wdata[ADDR_LSB  +: PA_W];
      req_wdata <= host_wdata[WDATA_LSB +: PD_W];
      req_wr    <= host_wdata[WREQ_BIT];
      req_rd    <= host_wdata[RREQ_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_load) rdata_q <= rd_value;
  end

  assign host_rdata = pack_view(req_addr, req_wdata, rdata_q, req_wr, req_rd, ack);

endmodule

// File: rtl/regport_seq.sv
module regport_seq
  import phy_regport_pkg::*;
#(
  parameter int ACK_LAT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_wr,
  input  logic            req_rd,
  input  logic [PA_W-1:0] req_addr,
  input  logic [PD_W-1:0] req_wdata,
  output logic            ack,
  output logic            phy_stb,
  output logic            phy_we,
  output logic            rd_load,
  output logic [PA_W-1:0] phy_addr,
  output logic [PD_W-1:0] phy_wdata
);

  localparam int CNT_W = (ACK_LAT < 2) ? 1 : $clog2(ACK_LAT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_LAT - 1);

  port_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             op_wr_q;
  logic [PA_W-1:0]  op_addr_q;
  logic [PD_W-1:0]  op_data_q;
  logic             ack_q;

  logic req_any, start, release_w;

  assign req_any   = req_wr | req_rd;
  assign start     = (state_q == PS_IDLE) && req_any;
  assign phy_stb   = (state_q == PS_WAIT) && (cnt_q == CNT_LAST);
  assign release_w = (state_q == PS_DONE) && !req_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= PS_IDLE;
      cnt_q     <= '0;
      op_wr_q   <= 1'b0;
      op_addr_q <= '0;
      op_data_q <= '0;
      ack_q     <= 1'b0;
    end else begin
      unique case (state_q)
        PS_IDLE: if (start) begin
          state_q   <= PS_WAIT;
          cnt_q     <= '0;
          op_wr_q   <= req_wr;   // write wins when both are set
          op_addr_q <= req_addr;
          op_data_q <= req_wdata;
        end
        PS_WAIT: begin
          if (phy_stb) begin
            state_q <= PS_DONE;
            ack_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PS_DONE: if (release_w) begin
          state_q <= PS_IDLE;
          ack_q   <= 1'b0;
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  assign ack       = ack_q;
  assign phy_we    = phy_stb &  op_wr_q;
  assign rd_load   = phy_stb & ~op_wr_q;
  assign phy_addr  = op_addr_q;
  assign phy_wdata = op_data_q;

  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (req_wr || req_rd)) |=> ack);

  // R4
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req_wr && !req_rd) |=> !ack);

  // R3
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(phy_stb));

  // R8
  no_start_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !phy_stb);

endmodule

// File: rtl/regport_dlyfile.sv
module regport_dlyfile
  import phy_regport_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [PA_W-1:0]           addr,
  input  logic [PD_W-1:0]           wdata,
  output logic [PD_W-1:0]           rdata,
  output logic [NUM_SLOTS*PD_W-1:0] dly_flat
);

  logic [PD_W-1:0] slot_q [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) slot_q[s] <= '0;
    end else if (we) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (addr == slot_to_addr(s)) slot_q[s] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (addr == slot_to_addr(s)) rdata = slot_q[s];
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flat
    assign dly_flat[g*PD_W +: PD_W] = slot_q[g];
  end

  // R7
  gap_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr_hit(addr)) |=> $stable(dly_flat));

  // R7
  gap_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit(addr) |-> (rdata == '0));

endmodule

// File: rtl/phy_regport.sv
module phy_regport
  import phy_regport_pkg::*;
#(
  parameter int ACK_LAT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_we,
  input  logic [31:0]               host_wdata,
  output logic [31:0]               host_rdata,
  output logic [NUM_SLOTS*PD_W-1:0] dly_flat
);

  logic            req_wr, req_rd, ack_w, phy_stb_w, phy_we_w, rd_load_w;
  logic [PA_W-1:0] req_addr, phy_addr;
  logic [PD_W-1:0] req_wdata, phy_wdata, phy_rdata;

  regport_hostreg u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .rd_load    (rd_load_w),
    .rd_value   (phy_rdata),
    .ack        (ack_w),
    .host_rdata (host_rdata),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_wr     (req_wr),
    .req_rd     (req_rd)
  );

  regport_seq #(.ACK_LAT(ACK_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_wr    (req_wr),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ack       (ack_w),
    .phy_stb   (phy_stb_w),
    .phy_we    (phy_we_w),
    .rd_load   (rd_load_w),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata)
  );

  regport_dlyfile u_file (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (phy_we_w),
    .addr     (phy_addr),
    .wdata    (phy_wdata),
    .rdata    (phy_rdata),
    .dly_flat (dly_flat)
  );

  // R5
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load_w |=> (host_rdata[RDATA_LSB +: PD_W] == $past(phy_rdata)));

  // R6
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_we_w |=> $stable(host_rdata[RDATA_LSB +: PD_W]));

endmodule

// File: tb/phy_regport_tb_top.sv
`timescale 1ns/1ps
module phy_regport_tb_top;

  localparam int LAT   = 3;
  localparam int NSLOT = 12;
  localparam logic [31:0] WRQ = 32'h0100_0000;
  localparam logic [31:0] RDQ = 32'h0200_0000;

  // {is_read, addr[5:0], data_or_expected[7:0]}
  localparam int NVEC = 14;
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 6'h00, 8'h11}, {1'b0, 6'h08, 8'h88}, {1'b0, 6'h0B, 8'hB1},
    {1'b0, 6'h0D, 8'hD5}, {1'b1, 6'h00, 8'h11}, {1'b1, 6'h08, 8'h88},
    {1'b0, 6'h09, 8'h99}, {1'b1, 6'h09, 8'h00}, {1'b1, 6'h0D, 8'hD5},
    {1'b0, 6'h3F, 8'h5A}, {1'b1, 6'h3F, 8'h00}, {1'b0, 6'h0C, 8'hC3},
    {1'b1, 6'h0C, 8'hC3}, {1'b1, 6'h0B, 8'hB1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [NSLOT*8-1:0] dly_flat;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] mdl [NSLOT];
  logic [7:0] last_rd = 8'h00;

  always #2 clk = ~clk;

  phy_regport #(.ACK_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dly_flat(dly_flat)
  );

  function automatic int slot_of(input logic [5:0] a);
    if (a <= 6'd8) return int'(a);
    if (a >= 6'd11 && a <= 6'd13) return int'(a) - 2;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1;
    host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic check_slots(input string tag);
    for (int s = 0; s < NSLOT; s++)
      check(tag, {24'h0, dly_flat[s*8 +: 8]}, {24'h0, mdl[s]});
  endtask

  // full handshake with edge-exact acknowledge checks (R3, R4)
  task automatic xfer(input bit rd, input logic [5:0] a, input logic [7:0] d);
    host_write({16'h0, d, 2'b00, a});
    host_write((rd ? RDQ : WRQ) | {16'h0, d, 2'b00, a});
    for (int k = 0; k < LAT; k++) @(negedge clk);
    check("R3 ack low before latency", {31'h0, host_rdata[26]}, 32'h0);
    @(negedge clk);
    check("R3 ack high after latency", {31'h0, host_rdata[26]}, 32'h1);
    host_write(32'h0);
    check("R4 ack held at clear edge", {31'h0, host_rdata[26]}, 32'h1);
    @(negedge clk);
    check("R4 ack released", {31'h0, host_rdata[26]}, 32'h0);
  endtask

  initial begin
    for (int s = 0; s < NSLOT; s++) mdl[s] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 host view", host_rdata, 32'h0);
    check("R1 delay bank", {31'h0, |dly_flat}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 R4 R5 R7 R9
    for (int i = 0; i < NVEC; i++) begin
      automatic bit          rd = VEC[i][14];
      automatic logic [5:0]  a  = VEC[i][13:8];
      automatic logic [7:0]  d  = VEC[i][7:0];
      xfer(rd, a, d);
      if (rd) begin
        last_rd = d;
        check("R5/R7 read field", {24'h0, host_rdata[23:16]}, {24'h0, d});
      end else begin
        if (slot_of(a) >= 0) mdl[slot_of(a)] = d;
        check("R5 read field held", {24'h0, host_rdata[23:16]}, {24'h0, last_rd});
      end
      check_slots("R9/R7 delay bank");
    end

    // R2 field layout, read-only bits, no access without request
    host_write(32'hFCFF_FFFF);
    check("R2 field view", host_rdata, {8'h00, last_rd, 16'hFF3F});
    repeat (LAT + 3) @(negedge clk);
    check("R2 no access started", {31'h0, host_rdata[26]}, 32'h0);
    check_slots("R2 delay bank unchanged");

    // R6 both request bits: write only
    host_write(32'h0000_7702);
    host_write(WRQ | RDQ | 32'h0000_7702);
    repeat (LAT + 1) @(negedge clk);
    check("R6 ack", {31'h0, host_rdata[26]}, 32'h1);
    mdl[2] = 8'h77;
    check_slots("R6 slot written");
    check("R6 read field unchanged", {24'h0, host_rdata[23:16]}, {24'h0, last_rd});
    host_write(32'h0);
    @(negedge clk);

    // R8 changes during busy ignored; request while acked ignored
    host_write(32'h0000_3303);
    host_write(WRQ | 32'h0000_3303);
    host_write(WRQ | 32'h0000_4404);
    repeat (LAT) @(negedge clk);
    check("R8 ack", {31'h0, host_rdata[26]}, 32'h1);
    mdl[3] = 8'h33;
    check_slots("R8 in-flight access kept");
    host_write(RDQ | 32'h0000_0003);
    repeat (LAT + 3) @(negedge clk);
    check("R8 ack still high", {31'h0, host_rdata[26]}, 32'h1);
    check("R8 no read while acked", {24'h0, host_rdata[23:16]}, {24'h0, last_rd});
    host_write(32'h0);
    @(negedge clk);
    check("R8 ack dropped", {31'h0, host_rdata[26]}, 32'h0);
    check_slots("R8 bank final");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule